// File: doc/BRIEF.md
# Microprogram Sequencer with Conditional Branching

This block is the control unit of a single-bus processor built in the microprogrammed style. A six-bit microprogram address register selects one word of a 64-entry control store. Each word holds one bit per datapath control strobe, plus the fields that pick the next address. The block drives the strobe bits straight onto `ctrlWord`. The datapath itself sits outside the block.

The next address is chosen as follows:
- **Default:** the address increments.
- **Dispatch:** a dispatch word jumps to the start of the routine for the opcode held in the instruction register.
- **Conditional branch:** a branch word tests one condition flag and jumps to its target only when that condition holds.
- **End:** a word with the end bit set returns to the first word of instruction fetch.
- **Memory wait:** a word that waits on memory holds the address until the memory reports completion.

The current microprogram address is brought out on `upcOut` so that the sequencing can be observed.

Top module: `microSeqUnit`

## Requirements
- R1: While `rstN` is low, `upcOut` is 0 and `ctrlWord` equals the fetch word 19'd3597. When `rstN` is released, sequencing starts from address 0.
- R2: A word with no branch, dispatch, end or wait effect advances `upcOut` by one on the next clock.
- R3: A word with the wait bit (bit 14) set holds `upcOut` for every cycle in which `memDone` is low. It advances on the first clock at which `memDone` is high. The fetch words at addresses 1 and 9 carry the wait bit.
- R4: The dispatch word at address 3 loads the start address of the opcode's routine. Opcode 0 starts at 8, opcode 1 at 25, opcode 2 at 30 and opcode 3 at 40.
- R5: A conditional branch word jumps to its target only when its condition holds, and otherwise advances by one. Address 30 tests Z clear with target 0. Address 40 tests N set with target 44.
- R6: A word with the end bit (bit 15) set, and no pending wait, sends `upcOut` to 0 on the next clock. The end words are at addresses 11, 27, 32, 41 and 44.
- R7: `ctrlWord` has one bit per strobe:
  - bit 0: PC out
  - bit 1: PC in
  - bit 2: address register in
  - bit 3: read
  - bit 4: write
  - bit 5: data register out
  - bit 6: data register load from memory
  - bit 7: IR in
  - bit 8: Y in
  - bit 9: ALU-A select (1 = constant 4, 0 = Y)
  - bit 10: add
  - bit 11: Z in
  - bit 12: Z out
  - bit 13: IR offset out
  - bit 14: wait
  - bit 15: end
  - bit 16: source register out
  - bit 17: destination register out
  - bit 18: destination register in
  
  The fetch word at address 0 sets bits 0, 2, 3, 9, 10 and 11. Its value is 3597.
- R8: The branch-if-negative routine behaves as follows:
  - Address 25 returns to 0 when N is 0, and otherwise goes on to 26.
  - Address 26 drives 11264: offset out, add and Z in, with A selecting Y.
  - Address 27 drives 36866: Z out, PC in and end.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irOp | input | 2 | Opcode field of the instruction register |
| flagN | input | 1 | Negative condition flag |
| flagZ | input | 1 | Zero condition flag |
| memDone | input | 1 | Memory operation complete |
| ctrlWord | output | 19 | Control strobes for the datapath |
| upcOut | output | 6 | Current microprogram address |

## Verification
The bench holds `memDone` low for long runs on the wait words. A sequencer that ignored the wait would skip ahead, and one that latched `memDone` late would stall a cycle too long. It drives each flag both ways at addresses 25, 30 and 40, which catches an inverted condition or a branch that always falls through. It dispatches every opcode, which catches a wrong start address. It also checks that end words return to 0 and do not fall into the next word. The exact control words at 0, 26 and 27 catch a misplaced strobe bit or a flipped ALU-A select.

// File: rtl/useqPkg.sv
package useqPkg;
  localparam int UADDR_W = 6;
  localparam int UDEPTH  = 1 << UADDR_W;
  localparam int OP_W    = 2;
  localparam int CW_W    = 19;

  localparam int B_PCOUT   = 0;
  localparam int B_PCIN    = 1;
  localparam int B_MARIN   = 2;
  localparam int B_READ    = 3;
  localparam int B_WRITE   = 4;
  localparam int B_MDROUT  = 5;
  localparam int B_MDRMEM  = 6;
  localparam int B_IRIN    = 7;
  localparam int B_YIN     = 8;
  localparam int B_SEL4    = 9;
  localparam int B_ADD     = 10;
  localparam int B_ZIN     = 11;
  localparam int B_ZOUT    = 12;
  localparam int B_OFFOUT  = 13;
  localparam int B_WAIT    = 14;
  localparam int B_END     = 15;
  localparam int B_SRCOUT  = 16;
  localparam int B_DSTOUT  = 17;
  localparam int B_DSTIN   = 18;

  typedef enum logic [1:0] {
    SEQ_NEXT     = 2'd0,
    SEQ_DISPATCH = 2'd1,
    SEQ_BRANCH   = 2'd2
  } seqOp_e;

  typedef enum logic [1:0] {
    COND_NCLR = 2'd0,
    COND_NSET = 2'd1,
    COND_ZCLR = 2'd2,
    COND_ZSET = 2'd3
  } cond_e;

  typedef struct packed {
    logic [CW_W-1:0]    sig;
    seqOp_e             op;
    cond_e              cond;
    logic [UADDR_W-1:0] target;
  } microWord_t;

  // strobes from sequencing control to the address datapath (one-hot)
  typedef struct packed {
    logic hold;
    logic toFetch;
    logic toStart;
    logic toTarget;
    logic toNext;
  } seqStrobe_t;

  function automatic logic [CW_W-1:0] bitOf(input int b);
    return CW_W'(1) << b;
  endfunction

  function automatic logic [UADDR_W-1:0] startAddr(input logic [OP_W-1:0] op);
    case (op)
      2'd0:    return UADDR_W'(8);
      2'd1:    return UADDR_W'(25);
      2'd2:    return UADDR_W'(30);
      default: return UADDR_W'(40);
    endcase
  endfunction
endpackage

// File: rtl/microStore.sv
module microStore
  import useqPkg::*;
#(
  parameter int ADDR_W = UADDR_W
) (
  input  logic [ADDR_W-1:0] addr,
  output microWord_t        word
);
  localparam int DEPTH = 1 << ADDR_W;

  function automatic microWord_t mk(input logic [CW_W-1:0] s, input seqOp_e o,
                                    input cond_e c, input int t);
    microWord_t w;
    w.sig    = s;
    w.op     = o;
    w.cond   = c;
    w.target = UADDR_W'(t);
    return w;
  endfunction

  always_comb begin
    // unused words: end only, back to fetch
    word = mk(bitOf(B_END), SEQ_NEXT, COND_NCLR, 0);
    if (int'(addr) < DEPTH) begin
      case (int'(addr))
        0:  word = mk(bitOf(B_PCOUT) | bitOf(B_MARIN) | bitOf(B_READ) | bitOf(B_SEL4)
                      | bitOf(B_ADD) | bitOf(B_ZIN), SEQ_NEXT, COND_NCLR, 0);
        1:  word = mk(bitOf(B_ZOUT) | bitOf(B_PCIN) | bitOf(B_YIN) | bitOf(B_MDRMEM)
                      | bitOf(B_WAIT), SEQ_NEXT, COND_NCLR, 0);
        2:  word = mk(bitOf(B_MDROUT) | bitOf(B_IRIN), SEQ_NEXT, COND_NCLR, 0);
        3:  word = mk('0, SEQ_DISPATCH, COND_NCLR, 0);
        // opcode 0: add memory operand to register
        8:  word = mk(bitOf(B_SRCOUT) | bitOf(B_MARIN) | bitOf(B_READ), SEQ_NEXT, COND_NCLR, 0);
        9:  word = mk(bitOf(B_DSTOUT) | bitOf(B_YIN) | bitOf(B_MDRMEM) | bitOf(B_WAIT),
                      SEQ_NEXT, COND_NCLR, 0);
        10: word = mk(bitOf(B_MDROUT) | bitOf(B_ADD) | bitOf(B_ZIN), SEQ_NEXT, COND_NCLR, 0);
        11: word = mk(bitOf(B_ZOUT) | bitOf(B_DSTIN) | bitOf(B_END), SEQ_NEXT, COND_NCLR, 0);
        // opcode 1: branch if negative
        25: word = mk('0, SEQ_BRANCH, COND_NCLR, 0);
        26: word = mk(bitOf(B_OFFOUT) | bitOf(B_ADD) | bitOf(B_ZIN), SEQ_NEXT, COND_NCLR, 0);
        27: word = mk(bitOf(B_ZOUT) | bitOf(B_PCIN) | bitOf(B_END), SEQ_NEXT, COND_NCLR, 0);
        // opcode 2: branch if zero
        30: word = mk('0, SEQ_BRANCH, COND_ZCLR, 0);
        31: word = mk(bitOf(B_OFFOUT) | bitOf(B_ADD) | bitOf(B_ZIN), SEQ_NEXT, COND_NCLR, 0);
        32: word = mk(bitOf(B_ZOUT) | bitOf(B_PCIN) | bitOf(B_END), SEQ_NEXT, COND_NCLR, 0);
        // opcode 3: move chosen by N
        40: word = mk('0, SEQ_BRANCH, COND_NSET, 44);
        41: word = mk(bitOf(B_OFFOUT) | bitOf(B_DSTIN) | bitOf(B_END), SEQ_NEXT, COND_NCLR, 0);
        44: word = mk(bitOf(B_SRCOUT) | bitOf(B_DSTIN) | bitOf(B_END), SEQ_NEXT, COND_NCLR, 0);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/seqCtrl.sv
module seqCtrl
  import useqPkg::*;
(
  input  microWord_t word,
  input  logic       flagN,
  input  logic       flagZ,
  input  logic       memDone,
  output seqStrobe_t strobe
);
  logic condOk;

  always_comb begin
    case (word.cond)
      COND_NCLR: condOk = !flagN;
      COND_NSET: condOk = flagN;
      COND_ZCLR: condOk = !flagZ;
      default:   condOk = flagZ;
    endcase
  end

  always_comb begin
    strobe = '0;
    if (word.sig[B_WAIT] && !memDone) begin
      strobe.hold = 1'b1;
    end else if (word.sig[B_END]) begin
      strobe.toFetch = 1'b1;
    end else begin
      case (word.op)
        SEQ_DISPATCH: strobe.toStart = 1'b1;
        SEQ_BRANCH: begin
          if (condOk) strobe.toTarget = 1'b1;
          else        strobe.toNext   = 1'b1;
        end
        default: strobe.toNext = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/seqPath.sv
module seqPath
  import useqPkg::*;
#(
  parameter int ADDR_W = UADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [OP_W-1:0]   irOp,
  input  logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] upc
);
  logic [ADDR_W-1:0] nextUpc;

  always_comb begin
    nextUpc = upc + ADDR_W'(1);
    if (strobe.hold)          nextUpc = upc;
    else if (strobe.toFetch)  nextUpc = '0;
    else if (strobe.toStart)  nextUpc = ADDR_W'(startAddr(irOp));
    else if (strobe.toTarget) nextUpc = target;
  end

  always_ff @(posedge clk) begin
    if (!rstN) upc <= '0;
    else       upc <= nextUpc;
  end

  AST_ONE_PATH: assert property (@(posedge clk) disable iff (!rstN)
    $onehot({strobe.hold, strobe.toFetch, strobe.toStart, strobe.toTarget, strobe.toNext})); // R5
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hold |=> $stable(upc)); // R3
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.toNext |=> upc == $past(upc) + ADDR_W'(1)); // R2
  AST_END_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    strobe.toFetch |=> upc == '0); // R6
  AST_DISPATCH_START: assert property (@(posedge clk) disable iff (!rstN)
    strobe.toStart |=> upc == ADDR_W'(startAddr($past(irOp)))); // R4
  AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    strobe.toTarget |=> upc == $past(target)); // R5
endmodule

// File: rtl/microSeqUnit.sv
module microSeqUnit
  import useqPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [OP_W-1:0]     irOp,
  input  logic                flagN,
  input  logic                flagZ,
  input  logic                memDone,
  output logic [CW_W-1:0]     ctrlWord,
  output logic [UADDR_W-1:0]  upcOut
);
  microWord_t word;
  seqStrobe_t strobe;
  logic [UADDR_W-1:0] upc;

  microStore #(.ADDR_W(UADDR_W)) uStore (.addr(upc), .word(word));

  seqCtrl uCtrl (.word(word), .flagN(flagN), .flagZ(flagZ), .memDone(memDone), .strobe(strobe));

  seqPath #(.ADDR_W(UADDR_W)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .irOp(irOp), .target(word.target), .upc(upc)
  );

  assign ctrlWord = word.sig;
  assign upcOut   = upc;

  AST_RESET_FETCH: assert property (@(posedge clk) !rstN |=> upcOut == '0); // R1
endmodule

// File: tb/tb_microSeqUnit.sv
module tb_microSeqUnit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] irOp = '0;
  logic flagN = 1'b0, flagZ = 1'b0, memDone = 1'b0;
  logic [18:0] ctrlWord;
  logic [5:0] upcOut;
  int checks = 0, fails = 0;
  int model = 0;
  string tag = "R1";
  bit done = 0;

  microSeqUnit dut (.clk(clk), .rstN(rstN), .irOp(irOp), .flagN(flagN), .flagZ(flagZ),
                    .memDone(memDone), .ctrlWord(ctrlWord), .upcOut(upcOut));

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int startOf(input int op);
    case (op) 0: return 8; 1: return 25; 2: return 30; default: return 40; endcase
  endfunction

  function automatic bit isEnd(input int a);
    return a == 11 || a == 27 || a == 32 || a == 41 || a == 44;
  endfunction

  function automatic int expNext(input int a, input int op, input bit n, input bit z, input bit m);
    if ((a == 1 || a == 9) && !m) return a;
    if (isEnd(a)) return 0;
    if (a == 3) return startOf(op);
    if (a == 25) return n ? 26 : 0;
    if (a == 30) return z ? 31 : 0;
    if (a == 40) return n ? 44 : 41;
    return a + 1;
  endfunction

  function automatic string tagOf(input int a, input bit m);
    if ((a == 1 || a == 9)) return "R3";
    if (isEnd(a)) return "R6";
    if (a == 3) return "R4";
    if (a == 25) return "R8";
    if (a == 30 || a == 40) return "R5";
    return "R2";
  endfunction

  task automatic checkState();
    chk(upcOut == 6'(model), tag, upcOut, model);
    if (model == 0) chk(ctrlWord == 19'd3597, "R7 fetch word", ctrlWord, 3597);
    if (model == 26) chk(ctrlWord == 19'd11264, "R8 word 26", ctrlWord, 11264);
    if (model == 27) chk(ctrlWord == 19'd36866, "R8 word 27", ctrlWord, 36866);
    if (model == 1 || model == 9) chk(ctrlWord[14] == 1'b1, "R3 wait bit", ctrlWord[14], 1);
  endtask

  task automatic cyc(input int op, input bit n, input bit z, input bit m);
    irOp = 2'(op); flagN = n; flagZ = z; memDone = m;
    tag = tagOf(model, m);
    model = expNext(model, op, n, z, m);
    @(negedge clk);
    checkState();
  endtask

  task automatic runInstr(input int op, input bit n, input bit z);
    cyc(op, n, z, 1); cyc(op, n, z, 1); cyc(op, n, z, 1);
    for (int k = 0; k < 6 && model != 0; k++) cyc(op, n, z, 1);
  endtask

  initial begin
    #100us;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(upcOut == 6'd0, "R1 reset address", upcOut, 0);
    chk(ctrlWord == 19'd3597, "R1 reset word", ctrlWord, 3597);
    rstN = 1'b1;
    model = 0;
    // R3: stall several cycles at address 1
    cyc(0, 0, 0, 0);
    for (int k = 0; k < 5; k++) cyc(0, 0, 0, 0);
    cyc(0, 0, 0, 1); cyc(0, 0, 0, 1);
    for (int k = 0; k < 6 && model != 0; k++) cyc(0, 0, 0, (k % 2) == 1);
    // R8: branch-if-negative both ways; R5 zero and N-set branches both ways
    runInstr(1, 0, 0);
    runInstr(1, 1, 0);
    runInstr(2, 0, 0);
    runInstr(2, 0, 1);
    runInstr(3, 0, 0);
    runInstr(3, 1, 0);
    runInstr(0, 1, 1);
    // random mix
    for (int k = 0; k < 4000; k++) begin
      cyc(int'($urandom_range(0, 3)), bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
          $urandom_range(0, 9) < 7);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule